// File: doc/BRIEF.md
# Command Queue Base Register

This block holds the descriptor of a circular command queue that lives in memory. The descriptor is one 64-bit register. It contains a valid flag, inner and outer cacheability codes, a shareability code, a 4 KB-aligned base physical address and a page-count field. Software reaches the register as two 32-bit halves over a plain read/write bus. The half is chosen by a select pin, and a read returns the selected half combinationally.

Next to the descriptor, the block keeps the byte offset of the next command that a consumer fetches. It presents the memory address of that command as base plus offset. The consumer takes commands through a valid/ready handshake. Each transfer moves the offset on by one 32-byte entry and wraps it at the end of the queue.

Two status inputs, queue enable and quiescent, gate software writes. A write only takes effect while the queue is disabled and quiescent. Otherwise the bus write is dropped. The handshake follows these back-pressure rules:
- Ready is high only while the descriptor is valid and the queue is enabled.
- The consumer may hold valid high for as long as it wants entries, and one entry is taken per cycle in which both are high.
- An accepted write always beats an advance in the same cycle. Because a write needs the queue disabled, ready is low whenever that happens.

Top module: `cmdq_base_reg`

## Requirements
- R1: Each 32-bit half (select 1 = bits 63:32, select 0 = bits 31:0) is written and read on its own. A write to one half leaves the other half's readback unchanged.
- R2: The high half reads as {valid[31], 0[30], inner[29:27], 000[26:24], outer[23:21], 0[20], addr[51:32] in [19:0]}. The low half reads as {addr[31:12] in [31:12], share[11:10], 00[9:8], size[7:0]}. The reserved bits read zero whatever was written.
- R3: After reset the valid bit (high half bit 31) is 0, the read offset is 0 and ready is low.
- R4: A shareability code of 2'b11 written to bits [11:10] is stored and read back as 2'b00. Codes 00, 01 and 10 read back as written.
- R5: Address bits [15:12] always read zero. Address bits at or above the implemented width PA_W (default 48) always read zero.
- R6: Every accepted write to either half sets the read offset to zero.
- R7: A write while enable is 1 or quiescent is 0 is ignored. Both halves and the read offset keep their values.
- R8: adv_ready_o equals valid AND enable. Each cycle with adv_valid_i and adv_ready_o both high adds 32 to the read offset. With the valid bit 0, adv_valid_i has no effect on the offset.
- R9: The offset wraps to 0 when an advance would reach 4096 × (size + 1) bytes.
- R10: fetch_addr_o equals the stored base address plus rd_offset_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| q_enable_i | input | 1 | Queue enabled status |
| q_quiescent_i | input | 1 | Queue quiescent status |
| bus_wr_i | input | 1 | Bus write strobe for the selected half |
| bus_hi_i | input | 1 | Half select: 1 = bits 63:32, 0 = bits 31:0 |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data of the selected half |
| adv_valid_i | input | 1 | Consumer requests the next entry |
| adv_ready_o | output | 1 | An entry can be taken this cycle |
| fetch_addr_o | output | 52 | Physical address of the next command |
| rd_offset_o | output | 20 | Current byte offset into the queue |

## Verification
The assertions take for granted that the size field only changes through an accepted write, which also clears the offset. The offset bound is checked against the size in force. They also take for granted that the status inputs and the bus strobe are synchronous to the clock and change only between edges. The stimulus drives every input one time unit after a rising edge. It raises adv_valid_i only in stretches with known enable and valid settings, and it checks each ignored write at the ports before the next stimulus is applied.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;
  localparam int ADDR_MAX = 52;
  localparam int PAGE_LG2 = 12;
  localparam int SIZE_W   = 8;
  localparam int OFF_W    = PAGE_LG2 + SIZE_W;

  typedef enum logic [1:0] {
    SH_NONE  = 2'b00,
    SH_INNER = 2'b01,
    SH_OUTER = 2'b10,
    SH_RSVD  = 2'b11
  } share_e;

  typedef struct packed {
    logic                vld;
    logic [2:0]          icache;
    logic [2:0]          ocache;
    logic [ADDR_MAX-1:0] base;
    share_e              share;
    logic [SIZE_W-1:0]   size;
  } desc_t;
endpackage

// File: rtl/cmdq_desc_reg.sv
module cmdq_desc_reg
  import cmdq_pkg::*;
#(
  parameter int PA_W = 48
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_fire,
  input  logic        wr_hi,
  input  logic [31:0] wr_data,
  output desc_t       desc_o
);
  localparam logic [ADDR_MAX-1:0] IMPL_MASK =
    (PA_W >= ADDR_MAX) ? {ADDR_MAX{1'b1}} : ((ADDR_MAX'(1) << PA_W) - ADDR_MAX'(1));
  localparam logic [ADDR_MAX-1:0] ADDR_MASK = IMPL_MASK & ~ADDR_MAX'(16'hFFFF);

  desc_t desc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      desc_q <= '0;
    end else if (wr_fire) begin
      if (wr_hi) begin
        desc_q.vld         <= wr_data[31];
        desc_q.icache      <= wr_data[29:27];
        desc_q.ocache      <= wr_data[23:21];
        desc_q.base[51:32] <= wr_data[19:0] & ADDR_MASK[51:32];
      end else begin
        desc_q.base[31:16] <= wr_data[31:16] & ADDR_MASK[31:16];
        desc_q.share       <= (wr_data[11:10] == 2'b11) ? SH_NONE : share_e'(wr_data[11:10]);
        desc_q.size        <= wr_data[7:0];
      end
    end
  end

  assign desc_o = desc_q;

  AST_SHARE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    desc_q.share != SH_RSVD); // R4
  AST_HI_KEEPS_LO: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && wr_hi) |=> ($stable(desc_q.size) && $stable(desc_q.share) &&
                            $stable(desc_q.base[31:0]))); // R1
  AST_LO_KEEPS_HI: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && !wr_hi) |=> ($stable(desc_q.vld) && $stable(desc_q.icache) &&
                             $stable(desc_q.ocache) && $stable(desc_q.base[51:32]))); // R1
  AST_IDLE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_fire |=> $stable(desc_q)); // R7
endmodule

// File: rtl/cmdq_rd_ptr.sv
module cmdq_rd_ptr
  import cmdq_pkg::*;
#(
  parameter int ENTRY_BYTES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              step,
  input  logic [SIZE_W-1:0] size,
  output logic [OFF_W-1:0]  off_o
);
  localparam int LW = OFF_W + 1;

  logic [OFF_W-1:0] off_q;
  logic [LW-1:0]    qlen;
  logic [LW-1:0]    nxt;
  logic             wrap;

  always_comb begin
    qlen = (LW'(size) + LW'(1)) << PAGE_LG2;
    nxt  = {1'b0, off_q} + LW'(ENTRY_BYTES);
    wrap = (nxt >= qlen);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    off_q <= '0;
    else if (clr)  off_q <= '0;
    else if (step) off_q <= wrap ? '0 : nxt[OFF_W-1:0];
  end

  assign off_o = off_q;

  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (off_q == '0)); // R6
  AST_OFF_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, off_q} < qlen)); // R9
  AST_OFF_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    ((off_q % ENTRY_BYTES) == 0)); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !step) |=> $stable(off_q)); // R7
  AST_STEP_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clr) |=> (off_q != $past(off_q))); // R8
endmodule

// File: rtl/cmdq_base_reg.sv
module cmdq_base_reg
  import cmdq_pkg::*;
#(
  parameter int PA_W        = 48,
  parameter int ENTRY_BYTES = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                q_enable_i,
  input  logic                q_quiescent_i,
  input  logic                bus_wr_i,
  input  logic                bus_hi_i,
  input  logic [31:0]         bus_wdata_i,
  output logic [31:0]         bus_rdata_o,
  input  logic                adv_valid_i,
  output logic                adv_ready_o,
  output logic [ADDR_MAX-1:0] fetch_addr_o,
  output logic [OFF_W-1:0]    rd_offset_o
);
  desc_t            desc;
  logic             wr_fire;
  logic             step;
  logic [OFF_W-1:0] off;

  assign wr_fire     = bus_wr_i && !q_enable_i && q_quiescent_i;
  assign adv_ready_o = desc.vld && q_enable_i;
  assign step        = adv_valid_i && adv_ready_o && !wr_fire;

  cmdq_desc_reg #(.PA_W(PA_W)) u_desc (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_fire (wr_fire),
    .wr_hi   (bus_hi_i),
    .wr_data (bus_wdata_i),
    .desc_o  (desc)
  );

  cmdq_rd_ptr #(.ENTRY_BYTES(ENTRY_BYTES)) u_ptr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (wr_fire),
    .step  (step),
    .size  (desc.size),
    .off_o (off)
  );

  always_comb begin
    if (bus_hi_i)
      bus_rdata_o = {desc.vld, 1'b0, desc.icache, 3'b000, desc.ocache, 1'b0, desc.base[51:32]};
    else
      bus_rdata_o = {desc.base[31:12], desc.share, 2'b00, desc.size};
  end

  assign fetch_addr_o = desc.base + ADDR_MAX'(off);
  assign rd_offset_o  = off;

  AST_BLOCKED_WR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_i && !q_quiescent_i && !q_enable_i) |=> $stable(rd_offset_o)); // R7
  AST_FETCH_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_addr_o[11:0] == rd_offset_o[11:0])); // R10
  AST_NO_ADV_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
    (!desc.vld && !wr_fire) |=> $stable(rd_offset_o)); // R8
endmodule

// File: tb/sim_cmdq_base_reg.sv
`timescale 1ns/1ps
module sim_cmdq_base_reg;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0, qui = 1'b1, wr = 1'b0, hi = 1'b0, av = 1'b0;
  logic [31:0] wd = '0;
  logic [31:0] rd;
  logic        ar;
  logic [51:0] fa;
  logic [19:0] off;
  int          n_run = 0, n_fail = 0;

  always #4 clk = ~clk;

  cmdq_base_reg u0 (
    .clk(clk), .rst_n(rst_n), .q_enable_i(en), .q_quiescent_i(qui),
    .bus_wr_i(wr), .bus_hi_i(hi), .bus_wdata_i(wd), .bus_rdata_o(rd),
    .adv_valid_i(av), .adv_ready_o(ar), .fetch_addr_o(fa), .rd_offset_o(off)
  );

  // {half select, write data, expected readback}
  localparam logic [64:0] VEC [8] = '{
    {1'b0, 32'hFFFF_FFFF, 32'hFFFF_00FF},
    {1'b1, 32'hFFFF_FFFF, 32'hB8E0_FFFF},
    {1'b0, 32'h1234_5C85, 32'h1234_0085},
    {1'b1, 32'h4000_0000, 32'h0000_0000},
    {1'b0, 32'h0000_0403, 32'h0000_0403},
    {1'b1, 32'h0012_3456, 32'h0000_3456},
    {1'b0, 32'h0000_0800, 32'h0000_0800},
    {1'b1, 32'hA800_0000, 32'hA800_0000}
  };

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(logic h, logic [31:0] d);
    hi = h; wd = d; wr = 1'b1;
    tick();
    wr = 1'b0;
  endtask

  task automatic bus_read(logic h, output logic [31:0] d);
    hi = h; #1; d = rd;
  endtask

  task automatic advance(int n);
    av = 1'b1;
    repeat (n) tick();
    av = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [31:0] last [2];
    logic        seen [2];
    seen[0] = 1'b0; seen[1] = 1'b0;
    repeat (3) tick();
    // R3: reset state
    bus_read(1'b1, v);
    chk("R3 valid", 64'(v[31]), 64'd0);
    chk("R3 offset", 64'(off), 64'd0);
    chk("R3 ready", 64'(ar), 64'd0);
    rst_n = 1'b1;
    tick();

    // R1 R2 R4 R5: table walk
    for (int i = 0; i < 8; i++) begin
      logic h;
      h = VEC[i][64];
      bus_write(h, VEC[i][63:32]);
      bus_read(h, v);
      chk("R2/R4/R5 readback", 64'(v), 64'(VEC[i][31:0]));
      last[h] = VEC[i][31:0]; seen[h] = 1'b1;
      if (seen[!h]) begin
        bus_read(!h, v);
        chk("R1 other half kept", 64'(v), 64'(last[!h]));
      end
    end

    // program: base 0x1_0010_0000, size 1 (8192 bytes), valid
    bus_write(1'b0, 32'h0010_0001);
    bus_write(1'b1, 32'h8000_0001);
    chk("R6 offset after write", 64'(off), 64'd0);
    chk("R8 ready needs enable", 64'(ar), 64'd0);
    en = 1'b1; #1;
    chk("R8 ready", 64'(ar), 64'd1);
    chk("R10 fetch at start", 64'(fa), 64'h1_0010_0000);
    advance(1);
    chk("R8 step 32", 64'(off), 64'd32);
    chk("R10 fetch", 64'(fa), 64'h1_0010_0020);
    advance(254);
    chk("R9 last entry", 64'(off), 64'd8160);
    chk("R10 fetch last", 64'(fa), 64'h1_0010_1FE0);
    advance(1);
    chk("R9 wrap", 64'(off), 64'd0);
    advance(3);
    chk("R8 three steps", 64'(off), 64'd96);

    // R7: writes blocked
    bus_write(1'b0, 32'h0020_0003);
    bus_read(1'b0, v);
    chk("R7 enabled write ignored", 64'(v), 64'h0010_0001);
    chk("R7 enabled offset kept", 64'(off), 64'd96);
    en = 1'b0; qui = 1'b0;
    bus_write(1'b1, 32'h0000_0000);
    bus_read(1'b1, v);
    chk("R7 busy write ignored", 64'(v), 64'h8000_0001);
    chk("R7 busy offset kept", 64'(off), 64'd96);

    // R6: accepted write clears offset
    qui = 1'b1;
    bus_write(1'b1, 32'h8000_0001);
    chk("R6 clear", 64'(off), 64'd0);

    // R9: size 0 wraps at 4096
    bus_write(1'b0, 32'h0010_0000);
    en = 1'b1;
    advance(127);
    chk("R9 size0 last", 64'(off), 64'd4064);
    advance(1);
    chk("R9 size0 wrap", 64'(off), 64'd0);
    advance(2);
    chk("R9 size0 after wrap", 64'(off), 64'd64);

    // R8: invalid descriptor ignores advance
    en = 1'b0;
    bus_write(1'b1, 32'h0000_0001);
    en = 1'b1; #1;
    chk("R8 ready low when invalid", 64'(ar), 64'd0);
    advance(5);
    chk("R8 no advance when invalid", 64'(off), 64'd0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule